// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block sits behind the pins of a serial flash device and turns the host's bit stream into decoded commands for a memory back-end. It runs on a fast local clock, `clk_i`. It brings chip select, serial clock and serial data into that clock, then finds the rising and falling clock edges. It collects an 8-bit opcode and then a 24-bit address, shifting the most significant bit first. When the frame is complete it issues one command pulse that carries the command kind and a 23-bit address.

For read commands the block fetches bytes from the back-end one byte ahead of the shifter. It then drives them on the serial output, one bit per falling clock edge. In a dual-output read it also turns the data input pin into a second output, so each falling edge carries two bits. For page program it delivers every further received byte as a write strobe.

Any opcode outside the supported set locks the transaction until chip select goes high. A transaction cut short before its frame completes does nothing.

Top module: `sflash_cmd_frontend`

## Requirements
- R1: Serial input is sampled on rising `sck_i` edges and the outputs `so_o`/`sio_o` change only after falling `sck_i` edges. A clock idling low or idling high gives identical results, provided that every `sck_i` high and low phase and every deselect interval lasts at least 4 `clk_i` periods.
- R2: The first 8 bits after `cs_ni` falls form the opcode, MSB first. The supported opcodes are 03h (read), 3Bh (dual-output read), 02h (page program) and 06h (write enable).
- R3: For 03h, 3Bh and 02h the next 24 bits are the address, MSB first. After the 24th bit, `cmd_valid_o` pulses for one `clk_i` cycle. With it, `cmd_kind_o` gives the kind (0 read, 1 dual read, 2 program, 3 write enable) and `cmd_addr_o` holds the low 23 address bits; the top address bit is discarded.
- R4: Opcode 06h raises `cmd_valid_o` right after the 8th bit, with kind 3 and address 0. All later bits of that transaction are ignored.
- R5: Any other opcode issues no command and no write strobe, and leaves both output enables low. This lasts until `cs_ni` goes high and then low again.
- R6: If `cs_ni` goes high before the opcode and address are complete, no command is issued. The next transaction is framed from its first bit.
- R7: A read command raises `rd_req_o` with the command address. `rd_data_i` must hold that byte in the cycle after `rd_req_o`. The next byte is requested when the current byte starts shifting out, with the address counting upward and wrapping from 7FFFFFh to 000000h.
- R8: In a 03h read, each byte leaves on `so_o` MSB first. The first bit follows the falling edge after the last address bit, and `so_oe_o` stays high from that edge until deselect.
- R9: In a 3Bh read, 8 dummy bits follow the address. After them, each falling edge drives two bits: `so_o` carries bits 7, 5, 3, 1 and `sio_o` carries bits 6, 4, 2, 0. `sio_oe_o` is high only in this data phase.
- R10: After a 02h address, every further 8 bits give a one-cycle `wr_valid_o` with that byte on `wr_data_o`, MSB first.
- R11: `so_oe_o` and `sio_oe_o` are low after reset, while deselected, during opcode, address and dummy bits, and throughout non-read transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock, at least 8 times the serial clock rate |
| rst_ni | input | 1 | Active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from host |
| si_i | input | 1 | Serial data from host |
| so_o | output | 1 | Serial data output (upper bit in dual mode) |
| so_oe_o | output | 1 | Output enable for `so_o`; low means high impedance |
| sio_o | output | 1 | Second data output on the input pin in dual mode |
| sio_oe_o | output | 1 | Output enable for `sio_o` |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_kind_o | output | 2 | Command kind: 0 read, 1 dual read, 2 program, 3 write enable |
| cmd_addr_o | output | 23 | Command address, top bit dropped |
| wr_valid_o | output | 1 | One-cycle program data strobe |
| wr_data_o | output | 8 | Program data byte |
| rd_req_o | output | 1 | Read byte request to back-end |
| rd_addr_o | output | 23 | Address of requested byte |
| rd_data_i | input | 8 | Requested byte, valid the cycle after `rd_req_o` |

## Verification
A single bit is walked across all 24 address positions, which shows that the shift order is correct and that the top bit is dropped. Every one of the 256 opcodes is then framed, with the two clock idle levels alternating, which separates the four supported kinds from the locked-out remainder. Reads are checked near the top of the address space to prove the wrap, and single and dual reads of known byte patterns show the bit-to-pin mapping. Aborts inside the opcode and inside the address are each followed by a clean read, and an unsupported opcode followed by a valid-looking read frame shows that the lockout holds.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_DREAD = 8'h3B;
    localparam logic [7:0] OPC_PROG  = 8'h02;
    localparam logic [7:0] OPC_WREN  = 8'h06;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_DREAD = 2'd1,
        CMD_PROG  = 2'd2,
        CMD_WREN  = 2'd3
    } cmd_kind_e;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_DUMMY,
        PH_RDATA,
        PH_WDATA,
        PH_LOCK,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/sfc_pin_sync.sv
module sfc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_ni,
    input  logic sck_i,
    input  logic si_i,
    output logic cs_n_o,
    output logic si_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] si;
        logic              sck_prev;
    } sync_t;

    localparam sync_t RST_VAL = '{cs: '1, sck: '0, si: '0, sck_prev: 1'b0};

    sync_t q, d;

    always_comb begin
        d = q;
        d.cs[0]  = cs_ni;
        d.sck[0] = sck_i;
        d.si[0]  = si_i;
        for (int i = 1; i < STAGES; i++) begin
            d.cs[i]  = q.cs[i-1];
            d.sck[i] = q.sck[i-1];
            d.si[i]  = q.si[i-1];
        end
        d.sck_prev = q.sck[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= RST_VAL;
        else         q <= d;
    end

    assign cs_n_o = q.cs[STAGES-1];
    assign si_o   = q.si[STAGES-1];
    assign rise_o = q.sck[STAGES-1] & ~q.sck_prev;
    assign fall_o = ~q.sck[STAGES-1] & q.sck_prev;

endmodule

// File: rtl/sfc_framer.sv
module sfc_framer
    import sfc_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int ADDR_W     = 23
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_n_i,
    input  logic              rise_i,
    input  logic              si_i,
    output logic              cmd_valid_o,
    output cmd_kind_e         cmd_kind_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic              wr_valid_o,
    output logic [7:0]        wr_data_o,
    output logic              rd_phase_o,
    output logic              dual_o
);

    localparam int ABITS = 8 * ADDR_BYTES;
    localparam int CNT_W = $clog2(ABITS);
    localparam int SR_W  = ABITS;

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [SR_W-1:0]   sr;
        cmd_kind_e         kind;
        logic              cmd_valid;
        logic [ADDR_W-1:0] addr;
        logic              wr_valid;
        logic [7:0]        wr_data;
    } frm_t;

    frm_t q, d;
    logic [SR_W-1:0] sr_next;

    always_comb begin
        d = q;
        d.cmd_valid = 1'b0;
        d.wr_valid  = 1'b0;
        sr_next     = {q.sr[SR_W-2:0], si_i};
        if (cs_n_i) begin
            d.ph  = PH_OPCODE;
            d.cnt = '0;
        end else if (rise_i) begin
            case (q.ph)
                PH_OPCODE: begin
                    d.sr  = sr_next;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(7)) begin
                        d.cnt = '0;
                        case (sr_next[7:0])
                            OPC_READ: begin
                                d.kind = CMD_READ;
                                d.ph   = PH_ADDR;
                            end
                            OPC_DREAD: begin
                                d.kind = CMD_DREAD;
                                d.ph   = PH_ADDR;
                            end
                            OPC_PROG: begin
                                d.kind = CMD_PROG;
                                d.ph   = PH_ADDR;
                            end
                            OPC_WREN: begin
                                d.kind      = CMD_WREN;
                                d.addr      = '0;
                                d.cmd_valid = 1'b1;
                                d.ph        = PH_DONE;
                            end
                            default: d.ph = PH_LOCK;
                        endcase
                    end
                end
                PH_ADDR: begin
                    d.sr  = sr_next;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(ABITS - 1)) begin
                        d.cnt       = '0;
                        d.cmd_valid = 1'b1;
                        d.addr      = sr_next[ADDR_W-1:0];
                        case (q.kind)
                            CMD_DREAD: d.ph = PH_DUMMY;
                            CMD_PROG:  d.ph = PH_WDATA;
                            default:   d.ph = PH_RDATA;
                        endcase
                    end
                end
                PH_DUMMY: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(7)) begin
                        d.cnt = '0;
                        d.ph  = PH_RDATA;
                    end
                end
                PH_WDATA: begin
                    d.sr  = sr_next;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(7)) begin
                        d.cnt      = '0;
                        d.wr_valid = 1'b1;
                        d.wr_data  = sr_next[7:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.ph        <= PH_OPCODE;
            q.cnt       <= '0;
            q.sr        <= '0;
            q.kind      <= CMD_READ;
            q.cmd_valid <= 1'b0;
            q.addr      <= '0;
            q.wr_valid  <= 1'b0;
            q.wr_data   <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_valid_o = q.cmd_valid;
    assign cmd_kind_o  = q.kind;
    assign cmd_addr_o  = q.addr;
    assign wr_valid_o  = q.wr_valid;
    assign wr_data_o   = q.wr_data;
    assign rd_phase_o  = (q.ph == PH_RDATA);
    assign dual_o      = (q.kind == CMD_DREAD);

endmodule

// File: rtl/sfc_tx.sv
module sfc_tx #(
    parameter int ADDR_W = 23
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_n_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              rd_phase_i,
    input  logic              dual_i,
    input  logic [7:0]        rd_data_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              sio_o,
    output logic              sio_oe_o
);

    localparam int BCNT_W = 3;

    typedef struct packed {
        logic              req;
        logic [ADDR_W-1:0] raddr;
        logic [ADDR_W-1:0] next_addr;
        logic              pend;
        logic [7:0]        pbyte;
        logic [7:0]        sh;
        logic [BCNT_W-1:0] bcnt;
        logic              so;
        logic              sio;
        logic              so_oe;
        logic              sio_oe;
    } tx_t;

    tx_t q, d;
    logic [7:0] byte_now;

    always_comb begin
        d        = q;
        d.req    = 1'b0;
        d.pend   = q.req;
        byte_now = (q.bcnt == '0) ? q.pbyte : q.sh;
        if (q.pend) d.pbyte = rd_data_i;
        if (cs_n_i) begin
            d.so_oe  = 1'b0;
            d.sio_oe = 1'b0;
            d.bcnt   = '0;
        end else if (start_i) begin
            d.req       = 1'b1;
            d.raddr     = start_addr_i;
            d.next_addr = start_addr_i + 1'b1;
            d.bcnt      = '0;
        end else if (fall_i && rd_phase_i) begin
            if (q.bcnt == '0) begin
                d.req       = 1'b1;
                d.raddr     = q.next_addr;
                d.next_addr = q.next_addr + 1'b1;
            end
            d.so_oe = 1'b1;
            d.so    = byte_now[7];
            if (dual_i) begin
                d.sio    = byte_now[6];
                d.sio_oe = 1'b1;
                d.sh     = byte_now << 2;
                d.bcnt   = (q.bcnt == BCNT_W'(3)) ? '0 : q.bcnt + 1'b1;
            end else begin
                d.sh   = byte_now << 1;
                d.bcnt = q.bcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign rd_req_o  = q.req;
    assign rd_addr_o = q.raddr;
    assign so_o      = q.so;
    assign so_oe_o   = q.so_oe;
    assign sio_o     = q.sio;
    assign sio_oe_o  = q.sio_oe;

endmodule

// File: rtl/sflash_cmd_frontend.sv
module sflash_cmd_frontend
    import sfc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_BYTES  = 3,
    parameter int ADDR_W      = 23
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cs_ni,
    input  logic              sck_i,
    input  logic              si_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              sio_o,
    output logic              sio_oe_o,
    output logic              cmd_valid_o,
    output logic [1:0]        cmd_kind_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic              wr_valid_o,
    output logic [7:0]        wr_data_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i
);

    logic      cs_s, si_s, rise_s, fall_s;
    logic      rd_phase, dual, rd_start;
    cmd_kind_e kind;

    sfc_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cs_ni  (cs_ni),
        .sck_i  (sck_i),
        .si_i   (si_i),
        .cs_n_o (cs_s),
        .si_o   (si_s),
        .rise_o (rise_s),
        .fall_o (fall_s)
    );

    sfc_framer #(.ADDR_BYTES(ADDR_BYTES), .ADDR_W(ADDR_W)) i_framer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cs_n_i      (cs_s),
        .rise_i      (rise_s),
        .si_i        (si_s),
        .cmd_valid_o (cmd_valid_o),
        .cmd_kind_o  (kind),
        .cmd_addr_o  (cmd_addr_o),
        .wr_valid_o  (wr_valid_o),
        .wr_data_o   (wr_data_o),
        .rd_phase_o  (rd_phase),
        .dual_o      (dual)
    );

    assign rd_start   = cmd_valid_o && ((kind == CMD_READ) || (kind == CMD_DREAD));
    assign cmd_kind_o = kind;

    sfc_tx #(.ADDR_W(ADDR_W)) i_tx (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cs_n_i       (cs_s),
        .fall_i       (fall_s),
        .start_i      (rd_start),
        .start_addr_i (cmd_addr_o),
        .rd_phase_i   (rd_phase),
        .dual_i       (dual),
        .rd_data_i    (rd_data_i),
        .rd_req_o     (rd_req_o),
        .rd_addr_o    (rd_addr_o),
        .so_o         (so_o),
        .so_oe_o      (so_oe_o),
        .sio_o        (sio_o),
        .sio_oe_o     (sio_oe_o)
    );

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic cs_s,
    input logic fall_s,
    input logic cmd_valid_o,
    input logic wr_valid_o,
    input logic rd_req_o,
    input logic so_o,
    input logic sio_o,
    input logic so_oe_o,
    input logic sio_oe_o
);

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_o |=> !cmd_valid_o); // R3

    AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |=> !wr_valid_o); // R10

    AST_RDREQ_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o |=> !rd_req_o); // R7

    AST_OUT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fall_s |=> ($stable(so_o) && $stable(sio_o))); // R1

    AST_OE_OFF_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_s |=> (!so_oe_o && !sio_oe_o)); // R11

    AST_DUAL_OE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sio_oe_o |-> so_oe_o); // R9

    AST_NO_OE_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_valid_o |-> !so_oe_o); // R10

endmodule

bind sflash_cmd_frontend sfc_checker i_sfc_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_s        (cs_s),
    .fall_s      (fall_s),
    .cmd_valid_o (cmd_valid_o),
    .wr_valid_o  (wr_valid_o),
    .rd_req_o    (rd_req_o),
    .so_o        (so_o),
    .sio_o       (sio_o),
    .so_oe_o     (so_oe_o),
    .sio_oe_o    (sio_oe_o)
);

// File: tb/test_sflash_cmd_frontend.sv
module test_sflash_cmd_frontend;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5 * CLK_PERIOD;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic        so_o, so_oe_o, sio_o, sio_oe_o;
    logic        cmd_valid_o, wr_valid_o, rd_req_o;
    logic [1:0]  cmd_kind_o;
    logic [22:0] cmd_addr_o, rd_addr_o;
    logic [7:0]  wr_data_o;
    logic [7:0]  rd_data_i = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    int n_cmd = 0;
    int n_wr = 0;
    bit finished = 0;
    logic [1:0]  last_kind;
    logic [22:0] last_addr;
    logic [7:0]  wr_log [0:15];
    bit cap_so [0:127];
    bit cap_sio [0:127];
    bit cap_oe [0:127];
    bit cap_soe [0:127];

    always #(CLK_PERIOD/2) clk = ~clk;

    sflash_cmd_frontend i_sflash_cmd_frontend (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cs_ni       (cs_n),
        .sck_i       (sck),
        .si_i        (si),
        .so_o        (so_o),
        .so_oe_o     (so_oe_o),
        .sio_o       (sio_o),
        .sio_oe_o    (sio_oe_o),
        .cmd_valid_o (cmd_valid_o),
        .cmd_kind_o  (cmd_kind_o),
        .cmd_addr_o  (cmd_addr_o),
        .wr_valid_o  (wr_valid_o),
        .wr_data_o   (wr_data_o),
        .rd_req_o    (rd_req_o),
        .rd_addr_o   (rd_addr_o),
        .rd_data_i   (rd_data_i)
    );

    function automatic logic [7:0] mem_byte(input logic [22:0] a);
        return a[7:0] ^ {a[14:8], 1'b0} ^ {1'b0, a[22:16]} ^ 8'hA5;
    endfunction

    // back-end model: one-cycle read latency
    always @(posedge clk) begin
        if (rd_req_o) rd_data_i <= mem_byte(rd_addr_o);
    end

    always @(posedge clk) begin
        if (cmd_valid_o) begin
            n_cmd++;
            last_kind = cmd_kind_o;
            last_addr = cmd_addr_o;
        end
        if (wr_valid_o) begin
            wr_log[n_wr % 16] = wr_data_o;
            n_wr++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic xfer(input bit m3, input logic [31:0] hdr, input int nh,
                        input logic [31:0] pay, input int np, input int nr);
        sck = m3;
        #(HALF);
        cs_n = 1'b0;
        #(HALF);
        for (int k = 0; k < nh + np + nr; k++) begin
            bit v;
            if (k < nh)           v = hdr[nh-1-k];
            else if (k < nh + np) v = pay[np-1-(k-nh)];
            else                  v = 1'b0;
            sck = 1'b0;
            si  = v;
            #(HALF);
            cap_so[k]  = so_o;
            cap_sio[k] = sio_o;
            cap_oe[k]  = so_oe_o;
            cap_soe[k] = sio_oe_o;
            sck = 1'b1;
            #(HALF);
        end
        if (!m3) sck = 1'b0;
        #(HALF);
        cs_n = 1'b1;
        #(2*HALF);
    endtask

    function automatic logic [7:0] single_byte(input int base);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7-i] = cap_so[base+i];
        return b;
    endfunction

    function automatic logic [7:0] dual_byte(input int base);
        logic [7:0] b;
        for (int p = 0; p < 4; p++) begin
            b[7-2*p] = cap_so[base+p];
            b[6-2*p] = cap_sio[base+p];
        end
        return b;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
        summary();
    end

    initial begin
        int c0;
        int w0;
        logic [22:0] a;
        logic [7:0]  got;
        @(negedge clk);
        repeat (5) @(negedge clk);
        // R11: reset state
        chk(!so_oe_o && !sio_oe_o, "R11 reset oe", {so_oe_o, sio_oe_o}, 0);
        chk(!cmd_valid_o, "R11 reset cmd", cmd_valid_o, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3 R1: walking one across address, A23 dropped, alternate clock idle levels
        for (int i = 0; i < 24; i++) begin
            logic [23:0] sent;
            sent = 24'd1 << i;
            c0 = n_cmd;
            xfer(i[0], {8'h03, sent}, 32, 0, 0, 0);
            chk(n_cmd == c0 + 1 && last_kind == 2'd0 && last_addr == sent[22:0],
                "R3 address walk", {1'b0, last_addr, 6'(n_cmd - c0), last_kind},
                {1'b0, sent[22:0], 6'd1, 2'd0});
        end

        // R7 R8: single read with wrap, idle-low clock
        c0 = n_cmd;
        xfer(1'b0, {8'h03, 24'hFFFFFE}, 32, 0, 0, 24);
        chk(n_cmd == c0 + 1 && last_addr == 23'h7FFFFE, "R3 read top addr", last_addr, 23'h7FFFFE);
        chk(!cap_oe[31] && cap_oe[32], "R8 oe start", {cap_oe[31], cap_oe[32]}, 2'b01);
        for (int j = 0; j < 3; j++) begin
            a = 23'h7FFFFE + 23'(j);
            got = single_byte(32 + 8*j);
            chk(got == mem_byte(a), "R7 wrap read byte", got, mem_byte(a));
        end
        chk(!cap_soe[40], "R9 no dual oe in single read", cap_soe[40], 0);
        chk(!so_oe_o, "R11 oe after deselect", so_oe_o, 0);

        // R1 R8: single read, idle-high clock
        xfer(1'b1, {8'h03, 24'h123456}, 32, 0, 0, 16);
        for (int j = 0; j < 2; j++) begin
            a = 23'h123456 + 23'(j);
            got = single_byte(32 + 8*j);
            chk(got == mem_byte(a), "R1 R8 read byte idle high", got, mem_byte(a));
        end

        // R9: dual read, idle-high clock
        c0 = n_cmd;
        xfer(1'b1, {8'h3B, 24'h80ABCD}, 32, 32'hFF, 8, 12);
        chk(n_cmd == c0 + 1 && last_kind == 2'd1 && last_addr == 23'h00ABCD,
            "R3 dual cmd", {last_kind, last_addr}, {2'd1, 23'h00ABCD});
        chk(!cap_oe[39] && !cap_soe[39] && cap_oe[40] && cap_soe[40], "R9 R11 dual oe",
            {cap_oe[39], cap_soe[39], cap_oe[40], cap_soe[40]}, 4'b0011);
        for (int j = 0; j < 3; j++) begin
            a = 23'h00ABCD + 23'(j);
            got = dual_byte(40 + 4*j);
            chk(got == mem_byte(a), "R9 dual byte", got, mem_byte(a));
        end

        // R10 R11: program, idle-low clock
        c0 = n_cmd;
        w0 = n_wr;
        xfer(1'b0, {8'h02, 24'h000100}, 32, 32'hC35A, 16, 0);
        chk(n_cmd == c0 + 1 && last_kind == 2'd2 && last_addr == 23'h000100,
            "R3 program cmd", {last_kind, last_addr}, {2'd2, 23'h000100});
        chk(n_wr == w0 + 2, "R10 write strobes", n_wr - w0, 2);
        chk(wr_log[w0 % 16] == 8'hC3 && wr_log[(w0+1) % 16] == 8'h5A, "R10 write data",
            {wr_log[w0 % 16], wr_log[(w0+1) % 16]}, 16'hC35A);
        begin
            bit any = 0;
            for (int k = 0; k < 48; k++) any |= cap_oe[k] | cap_soe[k];
            chk(!any, "R11 no oe in program", any, 0);
        end

        // R4: write enable, trailing bits ignored
        c0 = n_cmd;
        xfer(1'b1, 32'h06, 8, 32'h03000010, 32, 0);
        chk(n_cmd == c0 + 1 && last_kind == 2'd3 && last_addr == 23'h0,
            "R4 write enable", {6'(n_cmd - c0), last_kind, last_addr}, {6'd1, 2'd3, 23'h0});

        // R5: unsupported opcode locks out a following read frame
        c0 = n_cmd;
        w0 = n_wr;
        xfer(1'b0, 32'h9F, 8, 32'h03000010, 32, 8);
        chk(n_cmd == c0 && n_wr == w0, "R5 lockout no cmd", n_cmd - c0, 0);
        chk(!cap_oe[40] && !cap_soe[40], "R5 lockout no oe", {cap_oe[40], cap_soe[40]}, 0);
        xfer(1'b0, {8'h03, 24'h000777}, 32, 0, 0, 0);
        chk(n_cmd == c0 + 1 && last_addr == 23'h000777, "R5 recovery after deselect",
            last_addr, 23'h000777);

        // R6: abort in address, abort in opcode, then clean frame
        c0 = n_cmd;
        xfer(1'b0, {8'h03, 12'hABC}, 20, 0, 0, 0);
        chk(n_cmd == c0, "R6 abort in address", n_cmd - c0, 0);
        xfer(1'b1, 32'h15, 5, 0, 0, 0);
        chk(n_cmd == c0, "R6 abort in opcode", n_cmd - c0, 0);
        xfer(1'b1, {8'h03, 24'h2468AC}, 32, 0, 0, 8);
        chk(n_cmd == c0 + 1 && last_addr == 23'h2468AC, "R6 clean frame after abort",
            last_addr, 23'h2468AC);
        got = single_byte(32);
        chk(got == mem_byte(23'h2468AC), "R6 R8 read after abort", got, mem_byte(23'h2468AC));

        // R2: full opcode sweep
        for (int op = 0; op < 256; op++) begin
            int exp_n;
            logic [1:0] exp_k;
            exp_n = 1;
            exp_k = 2'd0;
            case (op)
                8'h03:   exp_k = 2'd0;
                8'h3B:   exp_k = 2'd1;
                8'h02:   exp_k = 2'd2;
                8'h06:   exp_k = 2'd3;
                default: exp_n = 0;
            endcase
            c0 = n_cmd;
            xfer(op[0], {8'(op), 24'h000042}, 32, 0, 0, 0);
            chk(n_cmd - c0 == exp_n && (exp_n == 0 || last_kind == exp_k), "R2 opcode sweep",
                {op[7:0], 6'(n_cmd - c0), last_kind}, {op[7:0], 6'(exp_n), exp_k});
        end

        summary();
    end

endmodule